// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the register interface of a four-channel DMA controller that sits on an 8-bit I/O bus. A host selects a register with a 4-bit offset and moves one byte per strobe. Each channel keeps a base and a current copy of its 16-bit address and 16-bit count. One byte pointer, shared by every 16-bit register, decides whether an access moves the low byte or the high byte. The upper half of the offset space carries commands: masking one channel, unmasking all, loading all masks at once, mode programming, pointer clear and master clear. It also holds a status register that reports terminal counts and is cleared when it is read.

The channel engines receive all register values, the mask bits, the auto-initialise and address-step flags, and a per-channel reload strobe. They send back one terminal-count pulse per channel and a level that shows a pending request. A terminal count on a channel with auto-initialise set copies the base registers into the current registers. The reload strobe then fires.

Read data is combinational. It is valid while the read strobe is high, and the side effects of a read take effect at the clock edge that ends the access.

Top module: `dmac_regif`

## Requirements
- R1: After reset all channel masks are set, auto-initialise and address-step flags are clear, all address and count registers are zero, the reload strobes are low and the byte pointer selects the low byte.
- R2: A write at offsets 0 to 7 targets channel offset[2:1]. An even offset selects the address register and an odd offset selects the count register. The byte is loaded into both the base copy and the current copy.
- R3: Every read or write at offsets 0 to 7 toggles one pointer that is shared by all channels and both register kinds. The first access after the pointer is cleared moves bits 7:0 and the next access moves bits 15:8.
- R4: A read at offsets 0 to 7 returns the byte selected by the pointer from the current copy of the register.
- R5: A write at offset 0xA sets the mask of channel data[1:0] to data[2]: 1 masks the channel and 0 unmasks it. The other channels keep their masks.
- R6: A write at offset 0xB loads, for channel data[1:0], auto-initialise from data[4] and the address-step flag from data[5]. The other channels keep their flags.
- R7: Any write at offset 0xC returns the byte pointer to the low-byte state.
- R8: Any write at offset 0xD sets all four masks, clears all terminal-count flags and returns the byte pointer to the low-byte state.
- R9: Any write at offset 0xE clears all four masks. A write at offset 0xF sets the mask of channel n from data[n].
- R10: A read at offset 0x8 returns the terminal-count flags in bits 3:0 (bit n for channel n) and the request inputs in bits 7:4 (bit 4+n for channel n). At the end of the read all terminal-count flags are cleared.
- R11: A terminal-count pulse that arrives in the same cycle as a status read or a master clear leaves its flag set for the next status read.
- R12: A terminal-count pulse on a channel with auto-initialise set copies that channel's base address and count into its current copies. The reload strobe of that channel is high in the following cycle. A channel without auto-initialise produces no reload strobe.
- R13: Writes at offset 0x9 have no effect. Reads at offsets 0x9 to 0xF return zero. Neither touches the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ofs | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, zero otherwise |
| ch_tc | input | 4 | Terminal-count pulses from the channel engines |
| ch_req | input | 4 | Request levels from the channel engines, reported in status |
| ch_base_addr | output | 64 | Base addresses, channel n at bits 16n+15:16n |
| ch_cur_addr | output | 64 | Current addresses, same packing |
| ch_base_cnt | output | 64 | Base counts, same packing |
| ch_cur_cnt | output | 64 | Current counts, same packing |
| ch_mask | output | 4 | Mask bits, 1 = masked |
| ch_autoinit | output | 4 | Auto-initialise flags |
| ch_step_sel | output | 4 | Address-step select flags |
| ch_reload | output | 4 | One-cycle reload strobes |

## Verification
The bench goes after the shared pointer first. It mixes reads and writes on different registers so that a design keeping one pointer per register would put the byte in the wrong half. It then clears the pointer after a single byte, with both the pointer-clear command and the master clear. A design that missed the clear would load the high byte instead of the low one.

Terminal-count pulses are driven in the same cycle as a status read and as a master clear. A design that let the clear win would drop the event and show a zero flag on the next read. The bench also checks that status reads clear the flags and leave the request bits alone. Reload strobes are checked on channels with and without auto-initialise. Ignored offsets are checked for side effects on the masks, the mode flags and the pointer.

// File: rtl/dmac_regif_pkg.sv
package dmac_regif_pkg;

   // Command offsets in the upper half of the offset space
   typedef enum logic [3:0] {
      OFS_STATUS  = 4'h8,
      OFS_SPARE   = 4'h9,
      OFS_MASK1   = 4'hA,
      OFS_MODE    = 4'hB,
      OFS_PTRCLR  = 4'hC,
      OFS_MCLR    = 4'hD,
      OFS_UNMASK  = 4'hE,
      OFS_MASKALL = 4'hF
   } ctl_ofs_e;

   // Decoded one-cycle command strobes
   typedef struct packed {
      logic mask_one;
      logic mode;
      logic ptr_clr;
      logic mclr;
      logic unmask_all;
      logic mask_all;
      logic stat_rd;
   } ctl_cmd_t;

   // Data bit positions used by the command registers
   localparam int MASK_BIT_POS  = 2;
   localparam int AUTO_BIT_POS  = 4;
   localparam int STEP_BIT_POS  = 5;

endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic toggle,
   input  logic clear,
   output logic hi_sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_sel <= 1'b0;
      else if (clear)  hi_sel <= 1'b0;
      else if (toggle) hi_sel <= ~hi_sel;
   end
endmodule

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank #(
   parameter int DATA_W = 8,
   localparam int REG_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              hi_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              reload,
   output logic [REG_W-1:0]  base_addr,
   output logic [REG_W-1:0]  cur_addr,
   output logic [REG_W-1:0]  base_cnt,
   output logic [REG_W-1:0]  cur_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         cur_addr  <= '0;
         base_cnt  <= '0;
         cur_cnt   <= '0;
      end else begin
         if (reload) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
         end
         if (wr_addr) begin
            if (hi_sel) begin
               base_addr[REG_W-1:DATA_W] <= wdata;
               cur_addr[REG_W-1:DATA_W]  <= wdata;
            end else begin
               base_addr[DATA_W-1:0] <= wdata;
               cur_addr[DATA_W-1:0]  <= wdata;
            end
         end
         if (wr_cnt) begin
            if (hi_sel) begin
               base_cnt[REG_W-1:DATA_W] <= wdata;
               cur_cnt[REG_W-1:DATA_W]  <= wdata;
            end else begin
               base_cnt[DATA_W-1:0] <= wdata;
               cur_cnt[DATA_W-1:0]  <= wdata;
            end
         end
      end
   end
endmodule

// File: rtl/dmac_ctl_stat.sv
module dmac_ctl_stat
   import dmac_regif_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DATA_W = 8,
   localparam int CH_W  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_cmd_t          cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NCH-1:0]    ch_tc,
   output logic [NCH-1:0]    mask,
   output logic [NCH-1:0]    autoinit,
   output logic [NCH-1:0]    step_sel,
   output logic [NCH-1:0]    tc_flags,
   output logic [NCH-1:0]    reload
);
   logic [CH_W-1:0] sel;
   logic [NCH-1:0]  tc_next;

   assign sel = wdata[CH_W-1:0];

   // A pulse in the clearing cycle survives the clear
   always_comb begin
      tc_next = (cmd.stat_rd || cmd.mclr) ? '0 : tc_flags;
      tc_next = tc_next | ch_tc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask     <= '1;
         autoinit <= '0;
         step_sel <= '0;
         tc_flags <= '0;
         reload   <= '0;
      end else begin
         tc_flags <= tc_next;
         reload   <= ch_tc & autoinit;
         if (cmd.mclr)            mask <= '1;
         else if (cmd.unmask_all) mask <= '0;
         else if (cmd.mask_all)   mask <= wdata[NCH-1:0];
         else if (cmd.mask_one)   mask[sel] <= wdata[MASK_BIT_POS];
         if (cmd.mode) begin
            autoinit[sel] <= wdata[AUTO_BIT_POS];
            step_sel[sel] <= wdata[STEP_BIT_POS];
         end
      end
   end
endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
   import dmac_regif_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DATA_W = 8,
   parameter int OFS_W  = 4,
   localparam int REG_W = 2 * DATA_W,
   localparam int CH_W  = $clog2(NCH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OFS_W-1:0]     bus_ofs,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NCH-1:0]       ch_tc,
   input  logic [NCH-1:0]       ch_req,
   output logic [NCH*REG_W-1:0] ch_base_addr,
   output logic [NCH*REG_W-1:0] ch_cur_addr,
   output logic [NCH*REG_W-1:0] ch_base_cnt,
   output logic [NCH*REG_W-1:0] ch_cur_cnt,
   output logic [NCH-1:0]       ch_mask,
   output logic [NCH-1:0]       ch_autoinit,
   output logic [NCH-1:0]       ch_step_sel,
   output logic [NCH-1:0]       ch_reload
);
   generate
      if (NCH != 4) begin : g_bad_nch
         $error("dmac_regif: channel select and status layout need NCH == 4");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("dmac_regif: bus width must be 8");
      end
      if (OFS_W != 4) begin : g_bad_ofs
         $error("dmac_regif: offset width must be 4");
      end
   endgenerate

   logic            chan_space;
   logic            ptr_hi;
   logic [CH_W-1:0] ch_sel;
   ctl_cmd_t        cmd;
   logic [NCH-1:0]  tc_flags;

   logic [REG_W-1:0] cur_addr_a [NCH];
   logic [REG_W-1:0] cur_cnt_a  [NCH];

   assign chan_space = ~bus_ofs[OFS_W-1];
   assign ch_sel     = bus_ofs[CH_W:1];

   always_comb begin
      cmd            = '0;
      cmd.mask_one   = bus_wr && (bus_ofs == OFS_MASK1);
      cmd.mode       = bus_wr && (bus_ofs == OFS_MODE);
      cmd.ptr_clr    = bus_wr && (bus_ofs == OFS_PTRCLR);
      cmd.mclr       = bus_wr && (bus_ofs == OFS_MCLR);
      cmd.unmask_all = bus_wr && (bus_ofs == OFS_UNMASK);
      cmd.mask_all   = bus_wr && (bus_ofs == OFS_MASKALL);
      cmd.stat_rd    = bus_rd && (bus_ofs == OFS_STATUS);
   end

   dmac_byte_ptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .toggle ((bus_wr || bus_rd) && chan_space),
      .clear  (cmd.ptr_clr || cmd.mclr),
      .hi_sel (ptr_hi)
   );

   dmac_ctl_stat #(.NCH(NCH), .DATA_W(DATA_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .wdata    (bus_wdata),
      .ch_tc    (ch_tc),
      .mask     (ch_mask),
      .autoinit (ch_autoinit),
      .step_sel (ch_step_sel),
      .tc_flags (tc_flags),
      .reload   (ch_reload)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_chan
      logic sel_here;
      assign sel_here = bus_wr && chan_space && (ch_sel == CH_W'(n));

      dmac_chan_bank #(.DATA_W(DATA_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_addr   (sel_here && !bus_ofs[0]),
         .wr_cnt    (sel_here &&  bus_ofs[0]),
         .hi_sel    (ptr_hi),
         .wdata     (bus_wdata),
         .reload    (ch_tc[n] && ch_autoinit[n]),
         .base_addr (ch_base_addr[n*REG_W +: REG_W]),
         .cur_addr  (ch_cur_addr[n*REG_W +: REG_W]),
         .base_cnt  (ch_base_cnt[n*REG_W +: REG_W]),
         .cur_cnt   (ch_cur_cnt[n*REG_W +: REG_W])
      );

      assign cur_addr_a[n] = ch_cur_addr[n*REG_W +: REG_W];
      assign cur_cnt_a[n]  = ch_cur_cnt[n*REG_W +: REG_W];
   end

   always_comb begin
      logic [REG_W-1:0] word;
      word      = bus_ofs[0] ? cur_cnt_a[ch_sel] : cur_addr_a[ch_sel];
      bus_rdata = '0;
      if (bus_rd) begin
         if (chan_space)
            bus_rdata = ptr_hi ? word[REG_W-1:DATA_W] : word[DATA_W-1:0];
         else if (bus_ofs == OFS_STATUS)
            bus_rdata = {ch_req, tc_flags};
      end
   end
endmodule

// File: rtl/dmac_regif_chk.sv
module dmac_regif_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [3:0]     bus_ofs,
   input logic           bus_wr,
   input logic           bus_rd,
   input logic [NCH-1:0] ch_tc,
   input logic [NCH-1:0] ch_mask,
   input logic [NCH-1:0] ch_autoinit,
   input logic [NCH-1:0] ch_reload,
   input logic           ptr_hi,
   input logic [NCH-1:0] tc_flags
);
   a_r3_ptr_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && !bus_ofs[3]) |=> (ptr_hi != $past(ptr_hi)));

   a_r7_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ofs == 4'hC) |=> !ptr_hi);

   a_r8_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ofs == 4'hD) |=> (ch_mask == '1 && !ptr_hi));

   a_r9_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ofs == 4'hE) |=> (ch_mask == '0));

   a_r10_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_ofs == 4'h8 && ch_tc == '0) |=> (tc_flags == '0));

   a_r11_tc_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_tc) |=> ((tc_flags & $past(ch_tc)) == $past(ch_tc)));

   a_r12_reload_follows_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_reload) |-> ((ch_reload & ~$past(ch_tc)) == '0));

   a_r13_spare_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ofs == 4'h9) |=> ($stable(ch_mask) && $stable(ch_autoinit) && $stable(ptr_hi)));
endmodule

bind dmac_regif dmac_regif_chk #(.NCH(NCH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_ofs     (bus_ofs),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .ch_tc       (ch_tc),
   .ch_mask     (ch_mask),
   .ch_autoinit (ch_autoinit),
   .ch_reload   (ch_reload),
   .ptr_hi      (ptr_hi),
   .tc_flags    (tc_flags)
);

// File: tb/dmac_regif_tb.sv
module dmac_regif_tb;
   localparam int CLK_NS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_ofs = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [3:0]  ch_tc = '0;
   logic [3:0]  ch_req = '0;
   logic [63:0] ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt;
   logic [3:0]  ch_mask, ch_autoinit, ch_step_sel, ch_reload;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   dmac_regif u_dut (
      .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_tc(ch_tc), .ch_req(ch_req),
      .ch_base_addr(ch_base_addr), .ch_cur_addr(ch_cur_addr), .ch_base_cnt(ch_base_cnt),
      .ch_cur_cnt(ch_cur_cnt), .ch_mask(ch_mask), .ch_autoinit(ch_autoinit),
      .ch_step_sel(ch_step_sel), .ch_reload(ch_reload)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] o, input logic [7:0] d, input logic [3:0] tc = 4'h0);
      @(negedge clk);
      bus_ofs = o; bus_wdata = d; bus_wr = 1'b1; ch_tc = tc;
      @(negedge clk);
      bus_wr = 1'b0; ch_tc = '0;
   endtask

   task automatic rd(input logic [3:0] o, output logic [7:0] d, input logic [3:0] tc = 4'h0);
      @(negedge clk);
      bus_ofs = o; bus_rd = 1'b1; ch_tc = tc;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; ch_tc = '0;
   endtask

   function automatic logic [15:0] fld(input logic [63:0] v, input int n);
      return v[n*16 +: 16];
   endfunction

   task automatic t_reset;
      logic [7:0] d;
      chk("R1 mask", ch_mask, 4'hF);
      chk("R1 autoinit", ch_autoinit, 4'h0);
      chk("R1 step", ch_step_sel, 4'h0);
      chk("R1 regs", ch_base_addr | ch_cur_addr | ch_base_cnt | ch_cur_cnt, 64'h0);
      chk("R1 reload", ch_reload, 4'h0);
      wr(4'h2, 8'h5A);
      chk("R1 pointer low", fld(ch_base_addr, 1), 16'h005A);
      wr(4'hC, 8'h00);
   endtask

   task automatic t_regs;
      wr(4'h0, 8'h34); wr(4'h0, 8'h12);
      chk("R2 ch0 base addr", fld(ch_base_addr, 0), 16'h1234);
      chk("R2 ch0 cur addr", fld(ch_cur_addr, 0), 16'h1234);
      wr(4'h7, 8'hCD); wr(4'h7, 8'hAB);
      chk("R2 ch3 base cnt", fld(ch_base_cnt, 3), 16'hABCD);
      chk("R2 ch3 cur cnt", fld(ch_cur_cnt, 3), 16'hABCD);
      chk("R2 ch3 addr untouched", fld(ch_base_addr, 3), 16'h0000);
   endtask

   task automatic t_read_ptr;
      logic [7:0] d;
      rd(4'h0, d); chk("R4 ch0 addr low", d, 8'h34);
      rd(4'h0, d); chk("R4 ch0 addr high", d, 8'h12);
      rd(4'h7, d); chk("R4 ch3 cnt low", d, 8'hCD);
      rd(4'h7, d); chk("R4 ch3 cnt high", d, 8'hAB);
      wr(4'h1, 8'h11);
      rd(4'h1, d); chk("R3 shared pointer read high", d, 8'h00);
      chk("R3 ch0 cnt", fld(ch_cur_cnt, 0), 16'h0011);
      wr(4'h4, 8'h55); wr(4'hC, 8'h00); wr(4'h4, 8'h66);
      chk("R7 pointer clear", fld(ch_base_addr, 2), 16'h0066);
      wr(4'hC, 8'h00);
   endtask

   task automatic t_mask;
      wr(4'hA, 8'h01); chk("R5 unmask ch1", ch_mask, 4'b1101);
      wr(4'hE, 8'h00); chk("R9 unmask all", ch_mask, 4'b0000);
      wr(4'hA, 8'h05); chk("R5 mask ch1", ch_mask, 4'b0010);
      wr(4'hF, 8'h0A); chk("R9 write all masks", ch_mask, 4'b1010);
      wr(4'h0, 8'hAA); wr(4'hD, 8'h00);
      chk("R8 master masks", ch_mask, 4'hF);
      wr(4'h0, 8'hBB);
      chk("R8 pointer reset", fld(ch_base_addr, 0), 16'h12BB);
      wr(4'hC, 8'h00);
   endtask

   task automatic t_mode;
      wr(4'hB, 8'h32);
      chk("R6 auto ch2", ch_autoinit, 4'b0100); chk("R6 step ch2", ch_step_sel, 4'b0100);
      wr(4'hB, 8'h21);
      chk("R6 step ch1", ch_step_sel, 4'b0110); chk("R6 auto kept", ch_autoinit, 4'b0100);
      wr(4'hB, 8'h02);
      chk("R6 ch2 off auto", ch_autoinit, 4'b0000); chk("R6 ch2 off step", ch_step_sel, 4'b0010);
      wr(4'hB, 8'h12);
      chk("R6 ch2 auto on", ch_autoinit, 4'b0100);
   endtask

   task automatic t_status;
      logic [7:0] d;
      ch_req = 4'b0101;
      @(negedge clk); ch_tc = 4'b0011;
      @(negedge clk); ch_tc = '0;
      rd(4'h8, d); chk("R10 status", d, 8'h53);
      rd(4'h8, d); chk("R10 cleared on read", d, 8'h50);
   endtask

   task automatic t_race;
      logic [7:0] d;
      rd(4'h8, d, 4'b0100); chk("R11 read during tc", d, 8'h50);
      rd(4'h8, d); chk("R11 tc kept over read", d, 8'h54);
      wr(4'hD, 8'h00, 4'b1000);
      rd(4'h8, d); chk("R11 tc kept over master clear", d, 8'h58);
      rd(4'h8, d); chk("R11 cleared", d, 8'h50);
   endtask

   task automatic t_reload;
      logic [7:0] d;
      @(negedge clk); ch_tc = 4'b0110;
      @(negedge clk); ch_tc = '0;
      chk("R12 reload ch2 only", ch_reload, 4'b0100);
      chk("R12 cur equals base", fld(ch_cur_addr, 2), fld(ch_base_addr, 2));
      @(negedge clk);
      chk("R12 reload one cycle", ch_reload, 4'b0000);
      rd(4'h8, d);
   endtask

   task automatic t_ignored;
      logic [7:0] d;
      wr(4'hE, 8'h00);
      wr(4'h9, 8'h0F);
      chk("R13 mask unchanged", ch_mask, 4'h0);
      chk("R13 mode unchanged", ch_autoinit, 4'b0100);
      wr(4'h0, 8'h99);
      chk("R13 pointer unchanged", fld(ch_base_addr, 0), 16'h1299);
      rd(4'hB, d); chk("R13 read B zero", d, 8'h00);
      rd(4'h9, d); chk("R13 read 9 zero", d, 8'h00);
      wr(4'h0, 8'h77);
      chk("R13 pointer still steps", fld(ch_base_addr, 0), 16'h7799);
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_read_ptr;
      t_mask;
      t_mode;
      t_status;
      t_race;
      t_reload;
      t_ignored;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule